// File: doc/BRIEF.md
# Two-Dimensional Strided Address Sequencer

This block walks one side of a memory transfer that is organised as rows. A descriptor supplies a start address, a row size in bytes minus one, a row count minus one, a row-to-row stride and a small transfer tag. The block then issues one address per bus-width beat on a valid/ready port. Within a row each address is the previous one plus the bus width. At the end of a row the next address is the start of that row plus the stride. Each beat is marked when it closes a row and when it closes the whole transfer.

Alongside the addresses it keeps a running byte count for the current transfer, which clears when the transfer ends. It also handles a stream end marker that arrives before the programmed size is reached. That early end stops the transfer, records how many bytes were moved and which tag they belonged to, and raises a sticky flag that software clears by reading the length and then the tag. After such an early end the block discards incoming descriptors until one arrives that carries the end-of-packet flag. A channel enable aborts any transfer and clears the recorded state.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After a synchronous reset, beat_valid, desc_ready, xfer_done and part_flag are 0, and progress and beat_addr are 0.
- R2: desc_ready is 1 exactly when enable is 1 and no transfer is running. An accepted descriptor (outside discard mode) makes beat_valid 1 on the next cycle with beat_addr equal to desc_start.
- R3: Within a row, each accepted beat (beat_valid and beat_ready both 1) advances beat_addr by BUS_BYTES. While beat_ready is 0, beat_valid and beat_addr hold.
- R4: A transfer has desc_ylen+1 rows of (desc_xlen+1)/BUS_BYTES beats each, where desc_xlen+1 is a multiple of BUS_BYTES. The first beat of row r is at desc_start + r*desc_stride, with addresses taken modulo 2^ADDR_W.
- R5: beat_row_last is 1 on the last beat of every row. beat_xfer_last is 1 only on the last beat of the last row. Both are 0 when beat_valid is 0.
- R6: progress equals BUS_BYTES times the beats accepted so far in the current transfer. It reads 0 in the cycle after the transfer ends, and in that cycle xfer_done is 1 for one cycle with xfer_done_id equal to the transfer's desc_id.
- R7: If strm_tlast is 1 on an accepted beat that is not the transfer's last, the transfer ends. part_len captures the byte count including that beat, part_id captures the tag, and part_flag is set. strm_tlast on the final beat leaves part_flag unchanged.
- R8: After an early end as in R7, descriptors are accepted and discarded with no beats issued. The first one with desc_tlast_en set is also discarded, and it ends discard mode.
- R9: part_flag clears after a part_len_rd strobe followed later by a part_id_rd strobe. A part_id_rd strobe with no earlier part_len_rd strobe leaves it set.
- R10: enable at 0 stops any running transfer, drops beat_valid, clears progress, part_flag and discard mode, and forces desc_ready to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_start | input | ADDR_W | Start address, bus aligned |
| desc_xlen | input | LEN_W | Row size in bytes minus one |
| desc_ylen | input | LEN_W | Row count minus one |
| desc_stride | input | LEN_W | Bytes between row starts, bus aligned |
| desc_id | input | ID_W | Transfer tag |
| desc_tlast_en | input | 1 | End-of-packet flag of the descriptor |
| beat_valid | output | 1 | Address beat offered |
| beat_ready | input | 1 | Address beat taken |
| beat_addr | output | ADDR_W | Address of the next data beat |
| beat_row_last | output | 1 | Beat closes a row |
| beat_xfer_last | output | 1 | Beat closes the transfer |
| strm_tlast | input | 1 | Stream end marker on the accepted beat |
| progress | output | LEN_W | Bytes moved in the current transfer |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| xfer_done_id | output | ID_W | Tag of the finished transfer |
| part_flag | output | 1 | Sticky early-end flag |
| part_len | output | PLEN_W | Bytes moved before the early end |
| part_id | output | ID_W | Tag of the early-ended transfer |
| part_len_rd | input | 1 | Strobe: partial length read |
| part_id_rd | input | 1 | Strobe: partial tag read |

## Verification
The bound checker checks, on every cycle, that a stalled beat holds its address, that an accepted beat inside a row steps by the bus width, and that progress grows by the bus width per beat. It also checks that the transfer's last beat clears progress and pulses done, that an early end raises the sticky flag and drops the beat, and that a disable clears the flag. Row-to-row stride jumps, the number of rows and beats, and the captured partial length and tag need a model of the whole descriptor, so the bench checks them in its sweeps. The same holds for the discard mode after an early end, the ordered read-out that clears the flag, and wrap-around at the top of the address space.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dma2d_beat_cnt.sv
// Beat and row counters; decides where a row and the transfer end.
module dma2d_beat_cnt #(
  parameter int LEN_W      = 24,
  parameter int BEAT_SHIFT = 2,
  parameter bit HAS_2D     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [LEN_W-1:0] xlen,
  input  logic [LEN_W-1:0] ylen,
  output logic             row_end,
  output logic             xfer_end
);
  logic [LEN_W-1:0] col_q, row_q, col_lim_q, row_lim_q;
  logic [LEN_W-1:0] row_lim_d;

  generate
    if (HAS_2D) begin : g_rows
      assign row_lim_d = ylen;
    end else begin : g_single
      assign row_lim_d = '0;
    end
  endgenerate

  assign row_end  = (col_q == col_lim_q);
  assign xfer_end = row_end && (row_q == row_lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q     <= '0;
      row_q     <= '0;
      col_lim_q <= '0;
      row_lim_q <= '0;
    end else if (load) begin
      col_q     <= '0;
      row_q     <= '0;
      col_lim_q <= xlen >> BEAT_SHIFT;
      row_lim_q <= row_lim_d;
    end else if (step) begin
      if (row_end) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma2d_addr_step.sv
// Current address and row base registers.
module dma2d_addr_step #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 24,
  parameter int BUS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              row_end,
  input  logic [ADDR_W-1:0] start,
  input  logic [LEN_W-1:0]  stride,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BUS_BYTES);

  logic [ADDR_W-1:0] base_q, addr_q, next_base;

  assign next_base = base_q + {{(ADDR_W-LEN_W){1'b0}}, stride};
  assign addr      = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      base_q <= start;
      addr_q <= start;
    end else if (step) begin
      if (row_end) begin
        base_q <= next_base;
        addr_q <= next_base;
      end else begin
        addr_q <= addr_q + STEP_A;
      end
    end
  end
endmodule

// File: rtl/dma2d_partial.sv
// Early-end capture with ordered read-out clear.
module dma2d_partial #(
  parameter int PLEN_W = 32,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              capture,
  input  logic [PLEN_W-1:0] cap_len,
  input  logic [ID_W-1:0]   cap_id,
  input  logic              len_rd,
  input  logic              id_rd,
  output logic              flag,
  output logic [PLEN_W-1:0] len,
  output logic [ID_W-1:0]   id
);
  logic flag_q, len_seen_q;
  logic [PLEN_W-1:0] len_q;
  logic [ID_W-1:0]   id_q;

  assign flag = flag_q;
  assign len  = len_q;
  assign id   = id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q     <= 1'b0;
      len_seen_q <= 1'b0;
      len_q      <= '0;
      id_q       <= '0;
    end else if (clr) begin
      flag_q     <= 1'b0;
      len_seen_q <= 1'b0;
    end else if (capture) begin
      flag_q     <= 1'b1;
      len_seen_q <= 1'b0;
      len_q      <= cap_len;
      id_q       <= cap_id;
    end else begin
      if (len_rd && flag_q) len_seen_q <= 1'b1;
      if (id_rd && len_seen_q) begin
        flag_q     <= 1'b0;
        len_seen_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 24,
  parameter int BUS_BYTES = 4,
  parameter int ID_W      = 2,
  parameter int PLEN_W    = 32,
  parameter bit HAS_2D    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_start,
  input  logic [LEN_W-1:0]  desc_xlen,
  input  logic [LEN_W-1:0]  desc_ylen,
  input  logic [LEN_W-1:0]  desc_stride,
  input  logic [ID_W-1:0]   desc_id,
  input  logic              desc_tlast_en,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_row_last,
  output logic              beat_xfer_last,
  input  logic              strm_tlast,
  output logic [LEN_W-1:0]  progress,
  output logic              xfer_done,
  output logic [ID_W-1:0]   xfer_done_id,
  output logic              part_flag,
  output logic [PLEN_W-1:0] part_len,
  output logic [ID_W-1:0]   part_id,
  input  logic              part_len_rd,
  input  logic              part_id_rd
);
  localparam int BEAT_SHIFT = $clog2(BUS_BYTES);
  localparam logic [LEN_W-1:0] STEP_B = LEN_W'(BUS_BYTES);

  seq_state_e        state_q;
  logic              skip_q, done_q;
  logic [ID_W-1:0]   id_q, done_id_q;
  logic [LEN_W-1:0]  prog_q, prog_inc;
  logic              row_end, xfer_end;
  logic              take, load, acc, early, fin;

  assign desc_ready = enable && (state_q == SEQ_IDLE);
  assign take       = desc_valid && desc_ready;
  assign load       = take && !skip_q;
  assign acc        = (state_q == SEQ_RUN) && beat_ready;
  assign early      = acc && strm_tlast && !xfer_end;
  assign fin        = acc && (xfer_end || strm_tlast);
  assign prog_inc   = prog_q + STEP_B;

  dma2d_beat_cnt #(.LEN_W(LEN_W), .BEAT_SHIFT(BEAT_SHIFT), .HAS_2D(HAS_2D)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .step(acc),
    .xlen(desc_xlen), .ylen(desc_ylen),
    .row_end(row_end), .xfer_end(xfer_end)
  );

  dma2d_addr_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) u_addr (
    .clk(clk), .rst(rst), .load(load), .step(acc), .row_end(row_end),
    .start(desc_start), .stride(desc_stride), .addr(beat_addr)
  );

  dma2d_partial #(.PLEN_W(PLEN_W), .ID_W(ID_W)) u_part (
    .clk(clk), .rst(rst), .clr(!enable), .capture(early && enable),
    .cap_len({{(PLEN_W-LEN_W){1'b0}}, prog_inc}), .cap_id(id_q),
    .len_rd(part_len_rd), .id_rd(part_id_rd),
    .flag(part_flag), .len(part_len), .id(part_id)
  );

  assign beat_valid     = (state_q == SEQ_RUN);
  assign beat_row_last  = beat_valid && row_end;
  assign beat_xfer_last = beat_valid && xfer_end;
  assign progress       = prog_q;
  assign xfer_done      = done_q;
  assign xfer_done_id   = done_id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      skip_q    <= 1'b0;
      done_q    <= 1'b0;
      id_q      <= '0;
      done_id_q <= '0;
      prog_q    <= '0;
    end else if (!enable) begin
      state_q <= SEQ_IDLE;
      skip_q  <= 1'b0;
      done_q  <= 1'b0;
      prog_q  <= '0;
    end else begin
      done_q    <= fin;
      done_id_q <= id_q;
      if (take) begin
        if (skip_q) begin
          if (desc_tlast_en) skip_q <= 1'b0;
        end else begin
          state_q <= SEQ_RUN;
          id_q    <= desc_id;
        end
      end
      if (acc) begin
        prog_q <= fin ? '0 : prog_inc;
        if (fin)   state_q <= SEQ_IDLE;
        if (early) skip_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 24,
  parameter int BUS_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              beat_row_last,
  input logic              beat_xfer_last,
  input logic              strm_tlast,
  input logic [LEN_W-1:0]  progress,
  input logic              xfer_done,
  input logic              part_flag
);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BUS_BYTES);
  localparam logic [LEN_W-1:0]  STEP_B = LEN_W'(BUS_BYTES);

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
    enable && beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    enable && beat_valid && beat_ready && !beat_row_last && !strm_tlast
    |=> beat_addr == $past(beat_addr) + STEP_A);

  a_r5_last_in_row: assert property (@(posedge clk) disable iff (rst)
    beat_xfer_last |-> beat_row_last && beat_valid);

  a_r6_progress_step: assert property (@(posedge clk) disable iff (rst)
    enable && beat_valid && beat_ready && !beat_xfer_last && !strm_tlast
    |=> progress == $past(progress) + STEP_B);

  a_r6_clear_on_end: assert property (@(posedge clk) disable iff (rst)
    enable && beat_valid && beat_ready && beat_xfer_last
    |=> progress == '0 && xfer_done && !beat_valid);

  a_r7_early_end: assert property (@(posedge clk) disable iff (rst)
    enable && beat_valid && beat_ready && strm_tlast && !beat_xfer_last
    |=> part_flag && !beat_valid && progress == '0);

  a_r10_disable: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !part_flag && !beat_valid && progress == '0);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_row_last(beat_row_last),
  .beat_xfer_last(beat_xfer_last), .strm_tlast(strm_tlast), .progress(progress),
  .xfer_done(xfer_done), .part_flag(part_flag)
);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [31:0] desc_start = '0;
  logic [23:0] desc_xlen = '0, desc_ylen = '0, desc_stride = '0;
  logic [1:0]  desc_id = '0;
  logic        desc_tlast_en = 1'b0;
  logic        beat_valid, beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic        beat_row_last, beat_xfer_last;
  logic        strm_tlast = 1'b0;
  logic [23:0] progress;
  logic        xfer_done;
  logic [1:0]  xfer_done_id;
  logic        part_flag;
  logic [31:0] part_len;
  logic [1:0]  part_id;
  logic        part_len_rd = 1'b0, part_id_rd = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  dma2d_addr_gen i_dma2d_addr_gen (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  task automatic send_desc(input logic [31:0] a, input int xl, input int yl,
                           input int st, input int id, input bit tle);
    @(negedge clk);
    desc_valid = 1'b1; desc_start = a; desc_xlen = 24'(xl); desc_ylen = 24'(yl);
    desc_stride = 24'(st); desc_id = 2'(id); desc_tlast_en = tle;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  // Runs one transfer; tl_at = beat index carrying strm_tlast, -1 for none.
  task automatic run_xfer(input logic [31:0] a, input int nb, input int nr,
                          input int st, input int id, input bit stall, input int tl_at);
    int  k = 0;
    int  total = nb * nr;
    bit  stop = 0;
    send_desc(a, nb * 4 - 1, nr - 1, st, id, 1'b1);
    for (int r = 0; r < nr && !stop; r++) begin
      for (int c = 0; c < nb && !stop; c++) begin
        logic [31:0] ea;
        bit rdy;
        ea = a + 32'(r * st) + 32'(c * 4);
        rdy = 0;
        while (!rdy) begin
          rdy = !stall || (cyc % 3 != 0);
          cyc++;
          beat_ready = rdy;
          strm_tlast = (k == tl_at);
          chk(beat_valid == 1'b1, "R2", "beat_valid", 64'(beat_valid), 1);
          chk(beat_addr == ea, (c == 0) ? "R4" : "R3", "beat_addr", 64'(beat_addr), 64'(ea));
          chk(beat_row_last == (c == nb - 1), "R5", "row_last", 64'(beat_row_last), 64'(c == nb - 1));
          chk(beat_xfer_last == (k == total - 1), "R5", "xfer_last",
              64'(beat_xfer_last), 64'(k == total - 1));
          chk(progress == 24'(k * 4), "R6", "progress", 64'(progress), 64'(k * 4));
          @(negedge clk);
        end
        if (k == tl_at) stop = 1;
        else k++;
      end
    end
    beat_ready = 1'b0;
    strm_tlast = 1'b0;
    chk(xfer_done == 1'b1, "R6", "xfer_done", 64'(xfer_done), 1);
    chk(xfer_done_id == 2'(id), "R6", "xfer_done_id", 64'(xfer_done_id), 64'(id));
    chk(progress == 24'd0, "R6", "progress cleared", 64'(progress), 0);
    chk(beat_valid == 1'b0, "R4", "idle after end", 64'(beat_valid), 0);
    if (tl_at >= 0 && tl_at < total - 1) begin
      chk(part_flag == 1'b1, "R7", "part_flag", 64'(part_flag), 1);
      chk(part_len == 32'((tl_at + 1) * 4), "R7", "part_len", 64'(part_len), 64'((tl_at + 1) * 4));
      chk(part_id == 2'(id), "R7", "part_id", 64'(part_id), 64'(id));
    end
  endtask

  task automatic pulse_rd(input bit l, input bit i);
    @(negedge clk);
    part_len_rd = l; part_id_rd = i;
    @(negedge clk);
    part_len_rd = 1'b0; part_id_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(beat_valid == 1'b0, "R1", "beat_valid", 64'(beat_valid), 0);
    chk(desc_ready == 1'b0, "R1", "desc_ready", 64'(desc_ready), 0);
    chk(progress == 24'd0, "R1", "progress", 64'(progress), 0);
    chk(part_flag == 1'b0, "R1", "part_flag", 64'(part_flag), 0);
    chk(xfer_done == 1'b0, "R1", "xfer_done", 64'(xfer_done), 0);
    chk(beat_addr == 32'd0, "R1", "beat_addr", 64'(beat_addr), 0);
    enable = 1'b1;
    @(negedge clk);
    chk(desc_ready == 1'b1, "R2", "desc_ready when enabled", 64'(desc_ready), 1);

    // R3 R4 R5 R6 sweep over shapes and ready patterns
    for (int nb = 1; nb <= 4; nb++)
      for (int nr = 1; nr <= 3; nr++)
        for (int s = 0; s < 2; s++)
          run_xfer(32'h1000 + 32'(nb * 256 + nr * 16), nb, nr, nb * 4 + 8 * nr,
                   (nb + nr) % 4, s[0], -1);
    run_xfer(32'h2000, 2, 3, 0, 1, 1'b1, -1);          // zero stride, rows overlay
    run_xfer(32'hFFFF_FFF0, 4, 2, 32, 3, 1'b0, -1);    // wrap at top of space

    // R7 strm_tlast on the final beat is not partial
    run_xfer(32'h3000, 3, 2, 16, 2, 1'b0, 5);
    chk(part_flag == 1'b0, "R7", "tlast on final beat", 64'(part_flag), 0);

    // R7 early end
    run_xfer(32'h4000, 3, 2, 16, 2, 1'b1, 3);

    // R8 discard mode
    send_desc(32'h5000, 7, 0, 0, 0, 1'b0);
    chk(beat_valid == 1'b0, "R8", "discarded descriptor", 64'(beat_valid), 0);
    chk(desc_ready == 1'b1, "R8", "ready in discard", 64'(desc_ready), 1);
    send_desc(32'h5100, 7, 0, 0, 0, 1'b0);
    chk(beat_valid == 1'b0, "R8", "second discard", 64'(beat_valid), 0);
    send_desc(32'h5200, 7, 0, 0, 0, 1'b1);
    chk(beat_valid == 1'b0, "R8", "flagged descriptor discarded", 64'(beat_valid), 0);
    run_xfer(32'h6000, 2, 2, 12, 1, 1'b0, -1);

    // R9 ordered read-out
    chk(part_flag == 1'b1, "R9", "flag still set", 64'(part_flag), 1);
    pulse_rd(1'b0, 1'b1);
    chk(part_flag == 1'b1, "R9", "id read alone", 64'(part_flag), 1);
    pulse_rd(1'b1, 1'b0);
    chk(part_flag == 1'b1, "R9", "after len read", 64'(part_flag), 1);
    pulse_rd(1'b0, 1'b1);
    chk(part_flag == 1'b0, "R9", "after len then id", 64'(part_flag), 0);

    // R10 disable clears flag and discard mode
    run_xfer(32'h7000, 2, 2, 8, 3, 1'b0, 0);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(part_flag == 1'b0, "R10", "flag cleared", 64'(part_flag), 0);
    chk(desc_ready == 1'b0, "R10", "desc_ready", 64'(desc_ready), 0);
    enable = 1'b1;
    run_xfer(32'h8000, 1, 2, 4, 0, 1'b0, -1);

    // R10 abort mid-transfer
    send_desc(32'h9000, 15, 3, 64, 2, 1'b1);
    beat_ready = 1'b1;
    repeat (2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    beat_ready = 1'b0;
    chk(beat_valid == 1'b0, "R10", "aborted beat_valid", 64'(beat_valid), 0);
    chk(progress == 24'd0, "R10", "aborted progress", 64'(progress), 0);
    enable = 1'b1;
    run_xfer(32'hA000, 3, 1, 0, 1, 1'b1, -1);

    summary();
    $finish;
  end
endmodule